// File: doc/BRIEF.md
# Gated Bidirectional Pulse Counter with Selectable Clear

This block keeps a 32-bit present value (PV) that moves by one on each rising edge of an external count pulse. A direction input chooses up or down counting, and the value wraps modulo 2^32. The count pulse and a reference-marker pulse come from outside the clock domain. Each passes through a two-flop synchronizer, and only its rising edges take effect.

Two control bits shape the counting:
- **Hold bit.** Freezes the PV against incoming pulses.
- **Zero bit.** Clears the PV. How it clears depends on a clear-mode select:
  - In software mode, the clear happens once, on the bit's rising edge.
  - In marker mode, the bit arms clearing, and every marker edge seen while it is high zeroes the PV. While armed in marker mode, the hold bit is overridden and counting carries on.

A clear and a count arriving in the same cycle resolve to a clear.

Top module: `hsc_top`

## Requirements
- R1: While `srst_i` is high, the PV is driven to 0 on each clock edge, and it stays 0 after release until a count or clear event occurs.
- R2: With `dir_i` = 1, each rising edge of `pulse_i` raises the PV by exactly 1. The update appears on the third clock edge after `pulse_i` is first sampled high.
- R3: With `dir_i` = 0, each rising edge of `pulse_i` lowers the PV by 1, wrapping from 0 to 32'hFFFF_FFFF.
- R4: A `pulse_i` held high for many cycles counts once.
- R5: With `hold_i` = 1 and the clear not armed in marker mode, pulses leave the PV unchanged. After `hold_i` returns to 0, later pulses count on from the held value.
- R6: With `mode_i` = 0 (software mode), the PV becomes 0 on the clock edge after `zero_i` is sampled rising. A `zero_i` that stays high does not clear the PV again.
- R7: In software mode, edges on `mark_i` have no effect on the PV.
- R8: With `mode_i` = 1 (marker mode), a rising edge of `mark_i` clears the PV while `zero_i` is high. A marker edge while `zero_i` is low, or a rising edge of `zero_i` on its own, leaves the PV unchanged.
- R9: In marker mode with `zero_i` high, `hold_i` is ignored and pulses keep counting.
- R10: When a clear and a count edge fall in the same cycle, the PV becomes 0 and the count is lost.
- R11: The block remembers the previous level of `zero_i` across a change of `mode_i`. Switching to software mode while `zero_i` is already high causes no clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| srst_i | input | 1 | Synchronous reset, active high |
| pulse_i | input | 1 | Asynchronous count pulse |
| dir_i | input | 1 | 1 = count up, 0 = count down |
| mark_i | input | 1 | Asynchronous reference-marker pulse |
| mode_i | input | 1 | Clear mode: 0 software, 1 marker |
| zero_i | input | 1 | Zero (clear) control bit |
| hold_i | input | 1 | Hold (gate) control bit |
| pv_o | output | 32 | Present value |

## Verification
The two timings differ because of the synchronizer.
- **Pulse and marker edges.** These show in `pv_o` on the third clock edge after the input is first sampled high: two synchronizer flops, then the PV register.
- **Software-mode clear.** The rising zero bit reaches `pv_o` on the next edge, with no synchronizer in its path.

The bench drives inputs on falling edges. Each pulse is held for two cycles and then low for two, so every result has settled before the following falling-edge sample.

For the same-cycle conflict, the bench raises the zero bit at the falling edge just before the cycle in which the count edge is due, so both are presented to the PV register on one edge.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

    typedef enum logic {
        MODE_SOFT = 1'b0,
        MODE_MARK = 1'b1
    } clr_mode_e;

    localparam int unsigned CH_PULSE = 0;
    localparam int unsigned CH_MARK  = 1;
    localparam int unsigned N_CH     = 2;

endpackage

// File: rtl/hsc_sync.sv
module hsc_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         srst_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] rise_o
);
    localparam int unsigned LAST = STAGES;

    typedef struct packed {
        logic [LAST:0][W-1:0] pipe;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = din_i;
        for (int i = 1; i <= LAST; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (srst_i) st_q <= '0;
        else        st_q <= st_d;
    end

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_edge
            assign rise_o[b] = st_q.pipe[LAST-1][b] & ~st_q.pipe[LAST][b];
        end
    endgenerate
endmodule

// File: rtl/hsc_ctrl.sv
module hsc_ctrl
    import hsc_pkg::*;
(
    input  logic      clk_i,
    input  logic      srst_i,
    input  clr_mode_e mode_i,
    input  logic      zero_i,
    input  logic      hold_i,
    input  logic      pulse_rise_i,
    input  logic      mark_rise_i,
    output logic      clr_o,
    output logic      step_o
);
    typedef struct packed {
        logic zero_prev;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        hold_eff;

    always_comb begin
        st_d           = st_q;
        st_d.zero_prev = zero_i;
        unique case (mode_i)
            MODE_SOFT: begin
                clr_o    = zero_i & ~st_q.zero_prev;
                hold_eff = hold_i;
            end
            default: begin
                clr_o    = zero_i & mark_rise_i;
                hold_eff = hold_i & ~zero_i;
            end
        endcase
        step_o = pulse_rise_i & ~hold_eff & ~clr_o;
    end

    always_ff @(posedge clk_i) begin
        if (srst_i) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hsc_pv.sv
module hsc_pv #(
    parameter int unsigned PV_W = 32
) (
    input  logic            clk_i,
    input  logic            srst_i,
    input  logic            clr_i,
    input  logic            step_i,
    input  logic            up_i,
    output logic [PV_W-1:0] pv_o
);
    localparam logic [PV_W-1:0] ONE = PV_W'(1);

    typedef struct packed {
        logic [PV_W-1:0] pv;
    } pv_state_t;

    pv_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.pv = '0;
        end else if (step_i) begin
            st_d.pv = up_i ? st_q.pv + ONE : st_q.pv - ONE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (srst_i) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pv_o = st_q.pv;
endmodule

// File: rtl/hsc_top.sv
module hsc_top
    import hsc_pkg::*;
#(
    parameter int unsigned PV_W        = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk_i,
    input  logic            srst_i,
    input  logic            pulse_i,
    input  logic            dir_i,
    input  logic            mark_i,
    input  logic            mode_i,
    input  logic            zero_i,
    input  logic            hold_i,
    output logic [PV_W-1:0] pv_o
);
    logic [N_CH-1:0] raw;
    logic [N_CH-1:0] rise;
    logic            clr;
    logic            step;
    clr_mode_e       mode;

    always_comb begin
        raw           = '0;
        raw[CH_PULSE] = pulse_i;
        raw[CH_MARK]  = mark_i;
        mode          = clr_mode_e'(mode_i);
    end

    hsc_sync #(.W(N_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .srst_i (srst_i),
        .din_i  (raw),
        .rise_o (rise)
    );

    hsc_ctrl u_ctrl (
        .clk_i        (clk_i),
        .srst_i       (srst_i),
        .mode_i       (mode),
        .zero_i       (zero_i),
        .hold_i       (hold_i),
        .pulse_rise_i (rise[CH_PULSE]),
        .mark_rise_i  (rise[CH_MARK]),
        .clr_o        (clr),
        .step_o       (step)
    );

    hsc_pv #(.PV_W(PV_W)) u_pv (
        .clk_i  (clk_i),
        .srst_i (srst_i),
        .clr_i  (clr),
        .step_i (step),
        .up_i   (dir_i),
        .pv_o   (pv_o)
    );
endmodule

// File: rtl/hsc_checker.sv
module hsc_checker #(
    parameter int unsigned PV_W = 32
) (
    input logic            clk_i,
    input logic            srst_i,
    input logic            mode_i,
    input logic            zero_i,
    input logic            hold_i,
    input logic [PV_W-1:0] pv_o
);
    localparam logic [PV_W-1:0] ONE = PV_W'(1);

    // R1
    a_r1_reset_zero: assert property (@(posedge clk_i)
        srst_i |=> pv_o == '0);

    // R2 / R3
    a_r2_unit_step: assert property (@(posedge clk_i) disable iff (srst_i)
        1'b1 |=> (pv_o == $past(pv_o)) || (pv_o == $past(pv_o) + ONE) ||
                 (pv_o == $past(pv_o) - ONE) || (pv_o == '0));

    // R5
    a_r5_hold_freezes: assert property (@(posedge clk_i) disable iff (srst_i)
        (hold_i && !zero_i) |=> $stable(pv_o));

    // R6
    a_r6_soft_clear: assert property (@(posedge clk_i) disable iff (srst_i)
        (!mode_i && zero_i && !$past(zero_i)) |=> pv_o == '0);

    // R8
    a_r8_no_clear_unarmed: assert property (@(posedge clk_i) disable iff (srst_i)
        !zero_i |=> (pv_o == $past(pv_o)) || (pv_o == $past(pv_o) + ONE) ||
                    (pv_o == $past(pv_o) - ONE));
endmodule

bind hsc_top hsc_checker #(.PV_W(PV_W)) u_chk (
    .clk_i  (clk_i),
    .srst_i (srst_i),
    .mode_i (mode_i),
    .zero_i (zero_i),
    .hold_i (hold_i),
    .pv_o   (pv_o)
);

// File: tb/sim_hsc_top.sv
module sim_hsc_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk_i = 1'b0;
    logic        srst_i = 1'b1;
    logic        pulse_i = 1'b0;
    logic        dir_i = 1'b1;
    logic        mark_i = 1'b0;
    logic        mode_i = 1'b0;
    logic        zero_i = 1'b0;
    logic        hold_i = 1'b0;
    logic [31:0] pv_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    hsc_top u0 (
        .clk_i  (clk_i),
        .srst_i (srst_i),
        .pulse_i(pulse_i),
        .dir_i  (dir_i),
        .mark_i (mark_i),
        .mode_i (mode_i),
        .zero_i (zero_i),
        .hold_i (hold_i),
        .pv_o   (pv_o)
    );

    task automatic check(input string req, input logic [31:0] exp);
        n_chk++;
        if (pv_o !== exp) begin
            n_bad++;
            $display("FAIL %s: pv actual %h expected %h", req, pv_o, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        srst_i = 1'b1; pulse_i = 0; mark_i = 0; zero_i = 0; hold_i = 0;
        mode_i = 0; dir_i = 1;
        cyc(3);
        srst_i = 1'b0;
        cyc(1);
    endtask

    task automatic pulse();
        pulse_i = 1'b1; cyc(2);
        pulse_i = 1'b0; cyc(2);
    endtask

    task automatic marker();
        mark_i = 1'b1; cyc(2);
        mark_i = 1'b0; cyc(2);
    endtask

    initial begin
        cyc(1);
        do_reset();
        check("R1", 32'd0);

        // R2 / R3: sweep direction and pulse count, incl. wrap below zero
        for (int d = 0; d < 2; d++) begin
            for (int n = 0; n < 6; n++) begin
                do_reset();
                dir_i = d[0];
                for (int k = 0; k < n; k++) pulse();
                check(d ? "R2" : "R3", d ? 32'(n) : 32'(0) - 32'(n));
            end
        end

        // R2: exact latency, update on third edge
        do_reset();
        pulse_i = 1'b1;
        cyc(2);
        check("R2", 32'd0);
        cyc(1);
        check("R2", 32'd1);
        pulse_i = 1'b0; cyc(2);

        // R4: held-high pulse counts once
        do_reset();
        pulse_i = 1'b1; cyc(12); pulse_i = 1'b0; cyc(3);
        check("R4", 32'd1);

        // R5: hold in both modes with zero low, then resume
        for (int m = 0; m < 2; m++) begin
            do_reset();
            mode_i = m[0];
            pulse(); pulse();
            hold_i = 1'b1;
            pulse(); pulse(); pulse();
            check("R5", 32'd2);
            hold_i = 1'b0;
            pulse();
            check("R5", 32'd3);
        end

        // R6: software clear on rise, no re-clear while held high
        do_reset();
        pulse(); pulse(); pulse();
        zero_i = 1'b1;
        cyc(1);
        check("R6", 32'd0);
        pulse(); pulse();
        check("R6", 32'd2);

        // R7: marker ignored in software mode, even with zero high
        marker();
        check("R7", 32'd2);
        zero_i = 1'b0; cyc(1);
        marker();
        check("R7", 32'd2);

        // R8: marker mode
        do_reset();
        mode_i = 1'b1;
        pulse(); pulse(); pulse();
        marker();
        check("R8", 32'd3);
        zero_i = 1'b1; cyc(3);
        check("R8", 32'd3);
        marker();
        check("R8", 32'd0);
        pulse(); marker();
        check("R8", 32'd0);

        // R9: hold overridden while armed in marker mode
        hold_i = 1'b1;
        pulse(); pulse();
        check("R9", 32'd2);
        zero_i = 1'b0; cyc(1);
        pulse();
        check("R9", 32'd2);
        hold_i = 1'b0; cyc(1);

        // R10: clear and count in the same cycle
        do_reset();
        pulse(); pulse(); pulse(); pulse(); pulse();
        check("R10", 32'd5);
        pulse_i = 1'b1; cyc(2);
        zero_i = 1'b1; cyc(1);
        check("R10", 32'd0);
        pulse_i = 1'b0; cyc(3);
        check("R10", 32'd0);

        // R11: mode change with zero already high gives no clear
        do_reset();
        mode_i = 1'b1; zero_i = 1'b1; cyc(1);
        pulse(); pulse();
        mode_i = 1'b0; cyc(2);
        check("R11", 32'd2);
        pulse();
        check("R11", 32'd3);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule